// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM. The host offers one word per request: an address, a read/write flag and, for writes, a data byte. It uses a valid/ready handshake. The controller turns each request into a timed sequence of chip-select, write-enable and output-enable levels on the memory pins. It also owns the shared bidirectional data bus and releases it whenever the memory might be driving.

Every phase lasts a whole number of system clock cycles, and each count is a parameter. The parameters are:

- address setup before the write strobe;
- write-strobe width;
- data hold after the strobe;
- write recovery;
- read access;
- read turnaround;
- overall minimum cycle.

A read returns its byte on `rspData` together with a one-cycle `rspValid` pulse. Every memory pin is driven from a register, so the pins change only on clock edges and cannot glitch.

Top module: `asram_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset with no request, chip select, write enable and output enable are all high, `reqReady` is 1 and `rspValid` is 0.
- R2: The pins encode a read as chip select low, write enable high, output enable low. They encode a write as chip select low and write enable low with output enable high. Successive chip-select falls are at least CYCLE_MIN cycles apart.
- R3: When write enable falls, chip select has been low and the address unchanged for at least ADDR_SETUP cycles.
- R4: Write enable stays low for at least WE_PULSE consecutive cycles.
- R5: The request's write data is on the bus for every cycle write enable is low, and in the first cycle after it rises. The address does not change while chip select is low, nor during the WR_RECOVER cycles after write enable rises.
- R6: Output enable is high in every cycle in which write enable is low.
- R7: For a read, chip select and output enable are low for at least RD_ACCESS cycles. The bus is sampled at the clock edge that ends that window. The sampled byte appears on `rspData` while `rspValid` is 1.
- R8: The controller drives the data bus only while output enable is high. It starts driving only after output enable has been high for at least RD_TURN cycles.
- R9: `rspValid` is a pulse exactly one cycle long, given once per read. `reqReady` is never high while chip select is low. A byte read back equals the last byte written to that address.
- R10: A request is taken only in a cycle where `reqValid` and `reqReady` are both 1. While `reqValid` is 0, chip select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Host offers a request |
| reqReady | output | 1 | Controller can take a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Byte to write |
| rspValid | output | 1 | One-cycle pulse: rspData holds read data |
| rspData | output | DATA_W | Byte returned by the last read |
| memCsN | output | 1 | Chip select to memory, active low |
| memWeN | output | 1 | Write enable to memory, active low |
| memOeN | output | 1 | Output enable to memory, active low |
| memAddr | output | ADDR_W | Address pins |
| memDq | inout | DATA_W | Bidirectional data pins |

## Verification
The assertions assume that the memory drives the data pins only while chip select is low, write enable is high and output enable is low. They also assume the host keeps `reqWrite`, `reqAddr` and `reqWdata` steady in the cycle it asserts `reqValid`.

The bench memory model drives the bus under exactly that pin condition and answers in the same cycle. Every request is raised on a falling edge, and only once `reqReady` is seen high. It is dropped on the next falling edge, so each request is offered for exactly one rising edge and taken once.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Strobes from the sequencer to the datapath; pin levels are active low.
  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
    logic drive;    // put write data on the bus
    logic capture;  // sample the bus into the read register
    logic load;     // latch the request address and data
  } strobe_t;

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int ADDR_SETUP = 2,
  parameter int WE_PULSE   = 3,
  parameter int DATA_HOLD  = 1,
  parameter int WR_RECOVER = 1,
  parameter int RD_ACCESS  = 7,
  parameter int RD_TURN    = 3,
  parameter int CYCLE_MIN  = 7
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  // Stretch the tail phase so that a whole access meets the cycle minimum.
  localparam int WR_PAD   = CYCLE_MIN - ADDR_SETUP - WE_PULSE - DATA_HOLD;
  localparam int REC_LEN  = (WR_RECOVER > WR_PAD) ? WR_RECOVER : WR_PAD;
  localparam int RD_PAD   = CYCLE_MIN - RD_ACCESS;
  localparam int TURN_LEN = (RD_TURN > RD_PAD) ? RD_TURN : RD_PAD;
  localparam int MAX_A    = (ADDR_SETUP > WE_PULSE) ? ADDR_SETUP : WE_PULSE;
  localparam int MAX_B    = (DATA_HOLD > REC_LEN) ? DATA_HOLD : REC_LEN;
  localparam int MAX_C    = (RD_ACCESS > TURN_LEN) ? RD_ACCESS : TURN_LEN;
  localparam int MAX_AB   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LEN  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSETUP, S_WPULSE, S_WHOLD, S_WREC, S_RACC, S_RTURN
  } phase_t;

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;

  always_comb begin
    lastCnt   = '0;
    phaseNext = S_IDLE;
    case (phase)
      S_WSETUP: begin lastCnt = CNT_W'(ADDR_SETUP - 1); phaseNext = S_WPULSE; end
      S_WPULSE: begin lastCnt = CNT_W'(WE_PULSE - 1);   phaseNext = S_WHOLD;  end
      S_WHOLD:  begin lastCnt = CNT_W'(DATA_HOLD - 1);  phaseNext = S_WREC;   end
      S_WREC:   begin lastCnt = CNT_W'(REC_LEN - 1);    phaseNext = S_IDLE;   end
      S_RACC:   begin lastCnt = CNT_W'(RD_ACCESS - 1);  phaseNext = S_RTURN;  end
      S_RTURN:  begin lastCnt = CNT_W'(TURN_LEN - 1);   phaseNext = S_IDLE;   end
      default:  begin lastCnt = '0;                     phaseNext = S_IDLE;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= S_IDLE;
      cnt   <= '0;
    end else if (phase == S_IDLE) begin
      cnt <= '0;
      if (reqValid) phase <= reqWrite ? S_WSETUP : S_RACC;
    end else if (cnt == lastCnt) begin
      phase <= phaseNext;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign reqReady = (phase == S_IDLE);

  always_comb begin
    strb      = '{csN: 1'b1, weN: 1'b1, oeN: 1'b1, drive: 1'b0, capture: 1'b0, load: 1'b0};
    strb.load = (phase == S_IDLE) && reqValid;
    case (phase)
      S_WSETUP: strb.csN = 1'b0;
      S_WPULSE: begin strb.csN = 1'b0; strb.weN = 1'b0; strb.drive = 1'b1; end
      S_WHOLD:  begin strb.csN = 1'b0; strb.drive = 1'b1; end
      S_RACC:   begin strb.csN = 1'b0; strb.oeN = 1'b0; end
      S_RTURN:  strb.capture = (cnt == '0);
      default:  ;
    endcase
  end

endmodule

// File: rtl/asram_ctrl_dp.sv
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq,
  output logic              dqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [DATA_W-1:0] wdataReg;

  // Pins are registered copies of the strobes, so they change only on edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      memCsN   <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      dqOe     <= 1'b0;
      rspValid <= 1'b0;
      memAddr  <= '0;
      wdataReg <= '0;
      rspData  <= '0;
    end else begin
      memCsN   <= strb.csN;
      memWeN   <= strb.weN;
      memOeN   <= strb.oeN;
      dqOe     <= strb.drive;
      rspValid <= strb.capture;
      if (strb.load) begin
        memAddr  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strb.capture) rspData <= memDq;
    end
  end

  assign memDq = dqOe ? wdataReg : 'z;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int ADDR_SETUP = 2,
  parameter int WE_PULSE   = 3,
  parameter int DATA_HOLD  = 1,
  parameter int WR_RECOVER = 1,
  parameter int RD_ACCESS  = 7,
  parameter int RD_TURN    = 3,
  parameter int CYCLE_MIN  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq
);

  strobe_t strb;
  logic    dqOe;

  asram_ctrl_fsm #(
    .ADDR_SETUP(ADDR_SETUP), .WE_PULSE(WE_PULSE), .DATA_HOLD(DATA_HOLD),
    .WR_RECOVER(WR_RECOVER), .RD_ACCESS(RD_ACCESS), .RD_TURN(RD_TURN),
    .CYCLE_MIN(CYCLE_MIN)
  ) u_fsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  asram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
    .memDq(memDq), .dqOe(dqOe), .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W     = 11,
  parameter int ADDR_SETUP = 2,
  parameter int WE_PULSE   = 3,
  parameter int RD_TURN    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memCsN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              dqOe
);

  int unsigned csLowCnt;
  int unsigned weLowCnt;
  int unsigned oeHighCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      csLowCnt  <= 0;
      weLowCnt  <= 0;
      oeHighCnt <= RD_TURN;
    end else begin
      csLowCnt  <= memCsN ? 0 : csLowCnt + 1;
      weLowCnt  <= memWeN ? 0 : weLowCnt + 1;
      oeHighCnt <= !memOeN ? 0 : ((oeHighCnt < RD_TURN) ? oeHighCnt + 1 : oeHighCnt);
    end
  end

  assert_setup_before_we_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(memWeN) |-> csLowCnt >= ADDR_SETUP);

  assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> weLowCnt >= WE_PULSE);

  assert_addr_held_R5: assert property (@(posedge clk) disable iff (rst)
    !memCsN |=> $stable(memAddr));

  assert_oe_off_in_write_R6: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> memOeN);

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
    dqOe |-> (memOeN && oeHighCnt >= RD_TURN));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> memCsN);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W), .ADDR_SETUP(ADDR_SETUP), .WE_PULSE(WE_PULSE), .RD_TURN(RD_TURN)
) u_chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .rspValid(rspValid),
  .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
  .dqOe(dqOe)
);

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int AS = 2, WP = 3, HOLD = 1, REC = 1, ACC = 7, TURN = 3, CYC = 7;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady, rspValid, memCsN, memWeN, memOeN;
  logic [DW-1:0] rspData;
  logic [AW-1:0] memAddr;
  wire  [DW-1:0] memDq;

  logic [DW-1:0] memModel [DEPTH];
  logic [DW-1:0] shadow   [DEPTH];
  logic [DW-1:0] curWdata = '0;
  int nChecks = 0;
  int nFail = 0;
  int pendingReads = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .ADDR_SETUP(AS), .WE_PULSE(WP), .DATA_HOLD(HOLD),
    .WR_RECOVER(REC), .RD_ACCESS(ACC), .RD_TURN(TURN), .CYCLE_MIN(CYC)
  ) u_asram_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memCsN(memCsN), .memWeN(memWeN),
    .memOeN(memOeN), .memAddr(memAddr), .memDq(memDq)
  );

  // Memory stand-in: drives the bus only in output mode, stores on the WE rise.
  wire memDrive = !memCsN && memWeN && !memOeN;
  assign memDq = memDrive ? memModel[memAddr] : 'z;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle protocol reference, sampled between edges.
  bit            prevCs = 1, prevWe = 1, prevRsp = 0, seenCsFall = 0;
  int            csLowRun = 0, oeLowRun = 0, weLowRun = 0, addrRun = 0;
  int            oeHighRun = 100, sinceCsFall = 0, sinceWeRise = 100;
  logic [AW-1:0] prevAddr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      check(!(reqReady && !memCsN), "R9 ready while selected", reqReady, 0);
      if (!memWeN) begin
        check(memOeN == 1'b1, "R6 oe during write", memOeN, 1);
        check(memDq == curWdata, "R5 data during pulse", memDq, curWdata);
      end
      if (prevWe && !memWeN) begin
        check(csLowRun >= AS, "R3 cs setup", csLowRun, AS);
        check(addrRun >= AS, "R3 addr setup", addrRun, AS);
        check(oeHighRun >= TURN, "R8 turnaround", oeHighRun, TURN);
        check(!memCsN, "R2 write encoding", memCsN, 0);
      end
      if (!prevWe && memWeN) begin
        check(weLowRun >= WP, "R4 pulse width", weLowRun, WP);
        check(memDq == curWdata, "R5 data hold", memDq, curWdata);
        if (!memCsN) memModel[memAddr] = memDq;
        sinceWeRise = 0;
      end
      if (prevCs && !memCsN) begin
        if (seenCsFall) check(sinceCsFall >= CYC, "R2 cycle time", sinceCsFall, CYC);
        seenCsFall  = 1;
        sinceCsFall = 0;
      end
      if (memAddr != prevAddr)
        check(prevCs && memCsN && sinceWeRise > REC, "R5 addr held", sinceWeRise, REC + 1);
      if (rspValid) begin
        check(oeLowRun >= ACC, "R7 access window", oeLowRun, ACC);
        check(!prevRsp, "R9 single pulse", prevRsp, 0);
        check(pendingReads > 0, "R9 response without read", pendingReads, 1);
        pendingReads--;
      end
      csLowRun  = memCsN ? 0 : csLowRun + 1;
      oeLowRun  = memOeN ? 0 : oeLowRun + 1;
      weLowRun  = memWeN ? 0 : weLowRun + 1;
      oeHighRun = memOeN ? oeHighRun + 1 : 0;
      addrRun   = (memAddr == prevAddr) ? addrRun + 1 : 1;
      sinceCsFall++;
      sinceWeRise++;
      prevCs   = memCsN;
      prevWe   = memWeN;
      prevRsp  = rspValid;
      prevAddr = memAddr;
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    if (wr) begin
      curWdata  = d;
      shadow[a] = d;
    end else begin
      pendingReads++;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input string req);
    int waitCnt;
    logic [DW-1:0] exp;
    exp = shadow[a];
    issue(1'b0, a, '0);
    waitCnt = 0;
    while (!rspValid && waitCnt < 50) begin
      @(negedge clk);
      waitCnt++;
    end
    check(rspValid && rspData == exp, req, rspData, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int csLowSeen;
    for (int i = 0; i < DEPTH; i++) begin
      memModel[i] = DW'((i * 7) ^ 8'h55);
      shadow[i]   = DW'((i * 7) ^ 8'h55);
    end
    repeat (4) @(negedge clk);
    // R1: state while in reset and just after
    check(memCsN && memWeN && memOeN, "R1 pins in reset", {memCsN, memWeN, memOeN}, 7);
    rst = 1'b0;
    @(negedge clk);
    check(memCsN && memWeN && memOeN, "R1 pins after reset", {memCsN, memWeN, memOeN}, 7);
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    check(rspValid == 1'b0, "R1 no response after reset", rspValid, 0);
    // R10: with no request the memory stays deselected
    csLowSeen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!memCsN) csLowSeen++;
    end
    check(csLowSeen == 0, "R10 idle with no request", csLowSeen, 0);
    // R7: untouched location returns the preloaded pattern
    readCheck(11'd100, "R7 read preload");
    // writes with several patterns, including the top address
    issue(1'b1, 11'd0, 8'h00);
    issue(1'b1, 11'd1, 8'hFF);
    issue(1'b1, 11'd2047, 8'hA5);
    issue(1'b1, 11'd5, 8'h5A);
    issue(1'b1, 11'd300, 8'h3C);
    readCheck(11'd0, "R9 readback 00");
    readCheck(11'd1, "R9 readback FF");
    readCheck(11'd2047, "R9 readback top address");
    readCheck(11'd5, "R9 readback 5A");
    readCheck(11'd300, "R9 readback 3C");
    // back-to-back write then read, and overwrite
    issue(1'b1, 11'd1, 8'h81);
    readCheck(11'd1, "R9 overwrite then read");
    readCheck(11'd2, "R7 read then write");
    issue(1'b1, 11'd2, 8'h7E);
    readCheck(11'd2, "R9 write after read");
    // mixed traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) issue(1'b1, AW'(lfsr[11:1]), lfsr[15:8]);
      else readCheck(AW'(lfsr[11:1]), "R7 mixed read");
    end
    repeat (20) @(negedge clk);
    check(pendingReads == 0, "R9 every read answered", pendingReads, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule